// File: doc/BRIEF.md
# Double-Precision Round and Pack Unit

This block takes the raw result of a floating-point operation and turns it into a packed IEEE-754 double along with the inexact, underflow and overflow flags. The result arrives as a sign, a signed unbiased exponent and a significand. The significand holds the leading one, the fraction bits and three extra guard, round and sticky bits at the bottom. The block aligns tiny values down into the denormal range with a sticky shift and rounds in one of four modes. If rounding carries out, it renormalises. Values too large to represent saturate according to the mode, and everything else is encoded as a normal or denormal word.

A flush control replaces any tiny input with a fixed result that depends on the mode. A trap-enable input for underflow makes exact denormal results report underflow as well. Tininess is decided after rounding, but only for an exponent exactly one below the minimum. There, a carry out of rounding promotes the value to the smallest normal. Each accepted input produces its result on the next clock edge, marked by a valid strobe. Arithmetic, NaN handling, exact-zero inputs and trapping are done by neighbouring logic.

Top module: `dp_round_pack`

## Requirements
- R1: `out_valid` is low after reset. In every cycle it equals `in_valid` sampled at the previous rising edge. The result and the flags are valid on that same cycle.
- R2: Rounding happens only when any of the three low significand bits is nonzero. `in_rnd_mode` encodes 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. Nearest-even adds 3 plus significand bit 3. Toward zero adds nothing. Toward +infinity adds 8 for a positive sign only. Toward -infinity adds 8 for a negative sign only.
- R3: If `in_flush_en` is set and the exponent is below the minimum normal exponent (-1022), both underflow and inexact are raised. Modes 0 and 1 then give a zero with the input sign. Mode 2 gives the smallest positive denormal for a positive sign and -0 for a negative sign. Mode 3 gives +0 for a positive sign and the smallest negative denormal for a negative sign.
- R4: An exponent of exactly -1023 is handled specially when flushing is off and rounding the input would carry above the leading-one position (bit 55). The value is then not tiny. Inexact is raised and underflow is not, and the result is the smallest normal with a zero fraction.
- R5: In every other case an exponent below -1022 shifts the significand right by (-1022 minus the exponent). Any shifted-out one is ORed into the sticky bit (bit 0), and the exponent becomes -1022. If the exponent was below -1023, the exponent field of the result is 0.
- R6: Nonzero low bits after alignment raise inexact. If bit 55 is also clear at that point, underflow is raised too.
- R7: A rounding carry above bit 55 shifts the significand right by one place and increments the exponent. The three low bits are then dropped.
- R8: An exponent above 1023 after rounding raises overflow and inexact. Mode 0 gives signed infinity, and mode 1 gives the signed largest finite value. Mode 2 gives +infinity for a positive sign or -max for a negative one. Mode 3 gives +max or -infinity.
- R9: If the leading bit is clear after rounding, the result has exponent field 0 and the raw fraction. Underflow is then also raised whenever `in_uf_trap_en` is set, even for an exact result.
- R10: A normal result uses exponent field (exponent + 1023) and drops the leading one from the fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input operands valid this cycle |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | 13 | Signed unbiased exponent |
| in_sig | input | 56 | Leading one, 52 fraction bits, guard, round, sticky |
| in_rnd_mode | input | 2 | Rounding mode, encoded as in R2 |
| in_flush_en | input | 1 | Replace tiny results with a fixed value that depends on the mode |
| in_uf_trap_en | input | 1 | Underflow trap enable, affects exact denormal flagging |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Packed double |
| out_inexact | output | 1 | Inexact flag |
| out_underflow | output | 1 | Underflow flag |
| out_overflow | output | 1 | Overflow flag |

## Verification
The packed word and all three flags are due together with `out_valid`, one rising edge after the input was presented with `in_valid` high. An idle input drops `out_valid` on that same edge. The bench drives each input on a falling edge and samples every output on the next falling edge, half a cycle after the register loads, so each vector takes exactly one cycle. The sweep covers the whole space of a narrow format with a 4-bit exponent and a 3-bit fraction. It crosses every normalised significand and every exponent from far below the denormal range to past the overflow point with all modes, signs, flush settings and trap-enable settings.

// File: rtl/dp_round_pkg.sv
package dp_round_pkg;

   typedef enum logic [1:0] {
      RND_NEAREST_EVEN = 2'd0,
      RND_TO_ZERO      = 2'd1,
      RND_TO_POS       = 2'd2,
      RND_TO_NEG       = 2'd3
   } rnd_mode_e;

   // Directed mode that moves magnitude away from zero for this sign
   function automatic logic rnd_away(input rnd_mode_e mode, input logic sign);
      return (mode == RND_TO_POS && !sign) || (mode == RND_TO_NEG && sign);
   endfunction

endpackage

// File: rtl/dp_rounder.sv
module dp_rounder
   import dp_round_pkg::*;
#(
   parameter int SIG_W = 56
) (
   input  logic             sign,
   input  rnd_mode_e        mode,
   input  logic [SIG_W-1:0] sig,
   output logic [SIG_W:0]   rounded,
   output logic             lost
);

   logic [SIG_W:0] incr;

   always_comb begin
      lost = |sig[2:0];
      incr = '0;
      if (lost) begin
         unique case (mode)
            RND_NEAREST_EVEN: incr = (SIG_W+1)'(3) + (SIG_W+1)'(sig[3]);
            RND_TO_ZERO:      incr = '0;
            default:          incr = rnd_away(mode, sign) ? (SIG_W+1)'(8) : '0;
         endcase
      end
      rounded = {1'b0, sig} + incr;
   end

endmodule

// File: rtl/dp_sticky_shift.sv
module dp_sticky_shift #(
   parameter int SIG_W = 56,
   parameter int AMT_W = 15
) (
   input  logic [SIG_W-1:0] din,
   input  logic [AMT_W-1:0] amt,
   output logic [SIG_W-1:0] dout
);

   logic [SIG_W-1:0] drop_mask;
   logic [SIG_W-1:0] shifted;
   logic             dropped;

   generate
      if (SIG_W >= 2**AMT_W) begin : g_bad_amt
         $error("dp_sticky_shift: AMT_W too narrow for SIG_W");
      end
      for (genvar i = 0; i < SIG_W; i++) begin : g_mask
         assign drop_mask[i] = (amt > AMT_W'(i));
      end
   endgenerate

   assign shifted = (amt >= AMT_W'(SIG_W)) ? '0 : (din >> amt);
   assign dropped = |(din & drop_mask);
   assign dout    = {shifted[SIG_W-1:1], shifted[0] | dropped};

endmodule

// File: rtl/dp_align.sv
module dp_align
   import dp_round_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int XE_W   = EXP_W + 2
) (
   input  logic                     sign,
   input  rnd_mode_e                mode,
   input  logic                     flush_en,
   input  logic signed [XE_W-1:0]   exp_in,
   input  logic [FRAC_W+3:0]        sig_in,
   output logic                     flush_hit,
   output logic signed [XE_W+1:0]   a_exp,
   output logic [FRAC_W+3:0]        a_sig,
   output logic                     a_inexact
);

   localparam int SIG_W = FRAC_W + 4;
   localparam int XI_W  = XE_W + 2;
   localparam int BIAS  = 2**(EXP_W-1) - 1;
   localparam int EMIN  = 1 - BIAS;

   logic signed [XI_W-1:0] exp_x;
   logic [XI_W-1:0]        shift_amt;
   logic [SIG_W:0]         pre_round;
   logic                   pre_lost;
   logic [SIG_W-1:0]       shifted;
   logic                   tiny_in;
   logic                   promote;
   logic                   unused_pre;

   assign exp_x     = XI_W'(exp_in);
   assign shift_amt = XI_W'(XI_W'(EMIN) - exp_x);
   assign tiny_in   = exp_x < XI_W'(EMIN);
   assign flush_hit = tiny_in && flush_en;
   assign promote   = (exp_x == XI_W'(EMIN - 1)) && pre_round[SIG_W];
   assign unused_pre = ^{pre_round[3:0], pre_lost};

   dp_rounder #(.SIG_W(SIG_W)) u_pre_round (
      .sign    (sign),
      .mode    (mode),
      .sig     (sig_in),
      .rounded (pre_round),
      .lost    (pre_lost)
   );

   dp_sticky_shift #(.SIG_W(SIG_W), .AMT_W(XI_W)) u_denorm_shift (
      .din  (sig_in),
      .amt  (shift_amt),
      .dout (shifted)
   );

   always_comb begin
      a_exp     = exp_x;
      a_sig     = sig_in;
      a_inexact = 1'b0;
      if (tiny_in && !flush_en) begin
         a_exp = XI_W'(EMIN);
         if (promote) begin
            // value rounds up to the smallest normal: no longer tiny
            a_sig     = {pre_round[SIG_W:4], 3'b000};
            a_inexact = 1'b1;
         end else begin
            a_sig = shifted;
         end
      end
   end

endmodule

// File: rtl/dp_pack.sv
module dp_pack
   import dp_round_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int XI_W   = EXP_W + 4
) (
   input  logic                      sign,
   input  rnd_mode_e                 mode,
   input  logic                      uf_trap_en,
   input  logic                      flush_hit,
   input  logic signed [XI_W-1:0]    a_exp,
   input  logic [FRAC_W+3:0]         a_sig,
   input  logic                      a_inexact,
   output logic [EXP_W+FRAC_W:0]     result,
   output logic                      inexact,
   output logic                      underflow,
   output logic                      overflow
);

   localparam int SIG_W = FRAC_W + 4;
   localparam int BIAS  = 2**(EXP_W-1) - 1;
   localparam int EMAX  = BIAS;

   localparam logic [EXP_W-1:0]  EXP_ONES = '1;
   localparam logic [EXP_W-1:0]  EXP_BIG  = EXP_ONES - EXP_W'(1);
   localparam logic [FRAC_W-1:0] FRAC_ONE = FRAC_W'(1);

   logic [SIG_W:0]          rounded;
   logic                    lost;
   logic [SIG_W-1:0]        norm_sig;
   logic signed [XI_W-1:0]  fin_exp;
   logic [FRAC_W:0]         mant;
   logic [XI_W-1:0]         biased;
   logic                    unused_bits;

   dp_rounder #(.SIG_W(SIG_W)) u_final_round (
      .sign    (sign),
      .mode    (mode),
      .sig     (a_sig),
      .rounded (rounded),
      .lost    (lost)
   );

   // carry-out renormalisation
   assign norm_sig = rounded[SIG_W] ? rounded[SIG_W:1] : rounded[SIG_W-1:0];
   assign fin_exp  = rounded[SIG_W] ? a_exp + XI_W'(1) : a_exp;
   assign mant     = norm_sig[SIG_W-1:3];
   assign biased   = XI_W'(fin_exp + XI_W'(BIAS));
   assign unused_bits = ^{norm_sig[2:0], biased[XI_W-1:EXP_W]};

   always_comb begin
      inexact   = a_inexact | lost;
      underflow = lost & ~a_sig[SIG_W-1];
      overflow  = 1'b0;
      if (flush_hit) begin
         inexact   = 1'b1;
         underflow = 1'b1;
         result    = {sign, {EXP_W{1'b0}}, rnd_away(mode, sign) ? FRAC_ONE : '0};
      end else if (fin_exp > XI_W'(EMAX)) begin
         overflow = 1'b1;
         inexact  = 1'b1;
         if (mode == RND_NEAREST_EVEN || rnd_away(mode, sign))
            result = {sign, EXP_ONES, {FRAC_W{1'b0}}};
         else
            result = {sign, EXP_BIG, {FRAC_W{1'b1}}};
      end else if (!mant[FRAC_W]) begin
         if (uf_trap_en) underflow = 1'b1;
         result = {sign, {EXP_W{1'b0}}, mant[FRAC_W-1:0]};
      end else begin
         result = {sign, biased[EXP_W-1:0], mant[FRAC_W-1:0]};
      end
   end

endmodule

// File: rtl/dp_round_pack.sv
module dp_round_pack
   import dp_round_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int XE_W   = EXP_W + 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic                       in_sign,
   input  logic signed [XE_W-1:0]     in_exp,
   input  logic [FRAC_W+3:0]          in_sig,
   input  logic [1:0]                 in_rnd_mode,
   input  logic                       in_flush_en,
   input  logic                       in_uf_trap_en,
   output logic                       out_valid,
   output logic [EXP_W+FRAC_W:0]      out_result,
   output logic                       out_inexact,
   output logic                       out_underflow,
   output logic                       out_overflow
);

   localparam int W     = 1 + EXP_W + FRAC_W;
   localparam int XI_W  = XE_W + 2;
   localparam int BIAS  = 2**(EXP_W-1) - 1;
   localparam int EMIN  = 1 - BIAS;
   localparam logic [EXP_W-1:0] EXP_ONES = '1;

   generate
      if (EXP_W < 3)         begin : g_bad_exp  $error("dp_round_pack: EXP_W below 3");  end
      if (FRAC_W < 2)        begin : g_bad_frac $error("dp_round_pack: FRAC_W below 2"); end
      if (XE_W < EXP_W + 2)  begin : g_bad_xe   $error("dp_round_pack: XE_W too narrow"); end
   endgenerate

   rnd_mode_e               mode;
   logic                    flush_hit;
   logic signed [XI_W-1:0]  a_exp;
   logic [FRAC_W+3:0]       a_sig;
   logic                    a_inexact;
   logic [W-1:0]            c_result;
   logic                    c_inexact, c_underflow, c_overflow;

   assign mode = rnd_mode_e'(in_rnd_mode);

   dp_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XE_W(XE_W)) u_align (
      .sign      (in_sign),
      .mode      (mode),
      .flush_en  (in_flush_en),
      .exp_in    (in_exp),
      .sig_in    (in_sig),
      .flush_hit (flush_hit),
      .a_exp     (a_exp),
      .a_sig     (a_sig),
      .a_inexact (a_inexact)
   );

   dp_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XI_W(XI_W)) u_pack (
      .sign       (in_sign),
      .mode       (mode),
      .uf_trap_en (in_uf_trap_en),
      .flush_hit  (flush_hit),
      .a_exp      (a_exp),
      .a_sig      (a_sig),
      .a_inexact  (a_inexact),
      .result     (c_result),
      .inexact    (c_inexact),
      .underflow  (c_underflow),
      .overflow   (c_overflow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_result    <= '0;
         out_inexact   <= 1'b0;
         out_underflow <= 1'b0;
         out_overflow  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result    <= c_result;
            out_inexact   <= c_inexact;
            out_underflow <= c_underflow;
            out_overflow  <= c_overflow;
         end
      end
   end

   // R1: result strobe follows the accepting edge
   assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R3: flushed tiny inputs leave a zero or one-ulp denormal with both flags
   assert_flush_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_flush_en && (in_exp < XE_W'(EMIN)))
      |=> (out_underflow && out_inexact && out_result[W-2 -: EXP_W] == '0
           && out_result[FRAC_W-1:0] <= FRAC_W'(1)));

   // R5: deeply tiny inputs always land in the denormal encoding
   assert_deep_denorm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_flush_en && (in_exp < XE_W'(EMIN - 1)))
      |=> (out_result[W-2 -: EXP_W] == '0));

   // R6: underflow only accompanies denormal or smallest-normal encodings
   assert_uf_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_underflow) |-> (out_result[W-2 -: EXP_W] <= EXP_W'(1)));

   // R8: overflow is inexact, never underflow, and saturates to inf or max
   assert_no_overflow_mix_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_overflow)
      |-> (out_inexact && !out_underflow
           && (out_result[W-2 -: EXP_W] == EXP_ONES
               || (out_result[W-2 -: EXP_W] == EXP_ONES - EXP_W'(1)
                   && out_result[FRAC_W-1:0] == '1))));

   // R9: with trap enable, any nonzero denormal encoding flags underflow
   assert_exact_denorm_uf_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_uf_trap_en && c_result[W-2 -: EXP_W] == '0
       && c_result[FRAC_W-1:0] != '0) |=> out_underflow);

endmodule

// File: tb/test_dp_round_pack.sv
`timescale 1ns/1ps
module test_dp_round_pack;

   localparam int EXP_W  = 4;
   localparam int FRAC_W = 3;
   localparam int XE_W   = EXP_W + 2;
   localparam int W      = 1 + EXP_W + FRAC_W;
   localparam int S      = FRAC_W + 4;
   localparam int BIAS   = 2**(EXP_W-1) - 1;
   localparam int EMIN   = 1 - BIAS;
   localparam int EMAX   = BIAS;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   in_valid = 1'b0;
   logic                   in_sign = 1'b0;
   logic signed [XE_W-1:0] in_exp = '0;
   logic [S-1:0]           in_sig = '0;
   logic [1:0]             in_rnd_mode = '0;
   logic                   in_flush_en = 1'b0;
   logic                   in_uf_trap_en = 1'b0;
   logic                   out_valid;
   logic [W-1:0]           out_result;
   logic                   out_inexact, out_underflow, out_overflow;

   int vectors = 0;
   int errors  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dp_round_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XE_W(XE_W)) i_dp_round_pack (
      .clk, .rst_n, .in_valid, .in_sign, .in_exp, .in_sig, .in_rnd_mode,
      .in_flush_en, .in_uf_trap_en, .out_valid, .out_result, .out_inexact,
      .out_underflow, .out_overflow
   );

   function automatic int rnd(input int s, input int m, input int md);
      if ((m & 7) == 0) return m;
      case (md)
         0: return m + 3 + ((m >> 3) & 1);
         2: return (s == 0) ? m + 8 : m;
         3: return (s != 0) ? m + 8 : m;
         default: return m;
      endcase
   endfunction

   task automatic model(input int s, input int e_in, input int m_in, input int md,
                        input int ftz, input int ue,
                        output logic [W-1:0] res, output logic ix, output logic uf,
                        output logic of, output string tag);
      int e = e_in;
      int m = m_in;
      ix = 0; uf = 0; of = 0; tag = "R10";
      if (e < EMIN) begin
         if (ftz != 0) begin
            ix = 1; uf = 1; tag = "R3";
            res = {s[0], EXP_W'(0), FRAC_W'(((md == 2 && s == 0) || (md == 3 && s != 0)) ? 1 : 0)};
            return;
         end
         if (e == EMIN - 1 && (rnd(s, m, md) >> S) != 0) begin
            ix = 1; tag = "R4";
            m = (rnd(s, m, md) >> 1) & ~7;
            e = EMIN;
         end else begin
            int es = EMIN - e;
            int lost = (es >= S) ? (m != 0) : ((m & ((1 << es) - 1)) != 0);
            m = (es >= S) ? 0 : (m >> es);
            m = m | lost;
            e = EMIN;
            tag = "R5";
         end
      end
      if ((m & 7) != 0) begin
         ix = 1;
         if (((m >> (S-1)) & 1) == 0) begin uf = 1; tag = "R6"; end
         else if (tag == "R10") tag = "R2";
         m = rnd(s, m, md);
         if ((m >> S) != 0) begin m = m >> 1; e = e + 1; tag = "R7"; end
      end
      m = m >> 3;
      if (e > EMAX) begin
         of = 1; ix = 1; tag = "R8";
         if (md == 0 || (md == 2 && s == 0) || (md == 3 && s != 0))
            res = {s[0], {EXP_W{1'b1}}, FRAC_W'(0)};
         else
            res = {s[0], EXP_W'((1 << EXP_W) - 2), {FRAC_W{1'b1}}};
      end else if (((m >> FRAC_W) & 1) == 0) begin
         if (ue != 0) begin uf = 1; if (ix == 0) tag = "R9"; end
         res = {s[0], EXP_W'(0), FRAC_W'(m)};
      end else begin
         res = {s[0], EXP_W'(e + BIAS), FRAC_W'(m)};
      end
   endtask

   // inputs change just after a falling edge; outputs are read one full cycle later
   task automatic apply(input int s, input int e, input int m, input int md,
                        input int ftz, input int ue);
      logic [W-1:0] x_res;
      logic x_ix, x_uf, x_of;
      string tag;
      model(s, e, m, md, ftz, ue, x_res, x_ix, x_uf, x_of, tag);
      in_valid      = 1'b1;
      in_sign       = s[0];
      in_exp        = XE_W'(e);
      in_sig        = S'(m);
      in_rnd_mode   = md[1:0];
      in_flush_en   = ftz[0];
      in_uf_trap_en = ue[0];
      @(negedge clk);
      vectors++;
      if (out_valid !== 1'b1 || out_result !== x_res || out_inexact !== x_ix
          || out_underflow !== x_uf || out_overflow !== x_of) begin
         errors++;
         $display("FAIL %s (and R1 valid) s=%0d e=%0d m=%0d mode=%0d ftz=%0d ue=%0d: got v=%b res=%h ix=%b uf=%b of=%b, expected v=1 res=%h ix=%b uf=%b of=%b",
                  tag, s, e, m, md, ftz, ue, out_valid, out_result, out_inexact,
                  out_underflow, out_overflow, x_res, x_ix, x_uf, x_of);
      end
   endtask

   task automatic check_idle(input string what);
      vectors++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 %s: out_valid got %b expected 0", what, out_valid);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_idle("during reset");           // R1 reset state
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("idle after reset");       // R1 no strobe without in_valid
      // Full sweep: R2 rounding, R3 flush, R4 boundary promotion, R5 sticky
      // shift, R6 tiny inexact, R7 carry, R8 overflow, R9 exact denormal, R10 normal
      for (int e = EMIN - S - 3; e <= EMAX + 2; e++)
         for (int m = (1 << (S-1)); m < (1 << S); m++)
            for (int md = 0; md < 4; md++)
               for (int s = 0; s < 2; s++)
                  for (int ftz = 0; ftz < 2; ftz++)
                     for (int ue = 0; ue < 2; ue++)
                        apply(s, e, m, md, ftz, ue);
      in_valid = 1'b0;
      @(negedge clk);
      check_idle("after dropping in_valid");  // R1
      apply(0, 0, (1 << (S-1)), 0, 0, 0);     // R10: exact 1.0 after a gap
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule